// File: doc/BRIEF.md
# Adaptive Page Refresh Scheduler

This block keeps charge-loss errors in flash pages below what a modest error-correcting code can repair. It sweeps a fixed range of page indices in ascending order. For each page it asks the flash controller for a read, waits for the external decoder's verdict, and then writes the corrected data back. The write-back is either a reprogram of the same location or a move to a spare physical page whose address arrives on an input.

The wait before each sweep comes from a four-entry interval table. The entry is chosen by comparing the block's program/erase count against three ascending thresholds, so heavily worn blocks are scrubbed more often. A per-page counter tracks consecutive in-place reprograms. Once it reaches a programmable ceiling, the next refresh of that page becomes a move and the counter starts again from zero, which bounds the program-disturb build-up. A page the decoder cannot repair is not written back; it is reported with its index and the sweep continues. Only one flash operation is in flight at any time, and a ready output tells the host to hold off its own traffic while a write-back is under way.

Top module: `adaptive_refresh_sched`

## Requirements
- R1: While reset is high and after it, until the first sweep, `cmd_valid` and `err_valid` are 0 and `host_ready` is 1; all per-page reprogram counters start at zero.
- R2: The sweep wait is INTV0 when `pe_count` < THR1, INTV1 when THR1 <= `pe_count` < THR2, INTV2 when THR2 <= `pe_count` < THR3, and INTV3 otherwise. After the write-back response of the last page of a sweep is accepted, the first read of the next sweep raises `cmd_valid` exactly interval+2 clock edges later.
- R3: `pe_count` is sampled once per sweep, one edge after the previous sweep ends. A change after that point has no effect on the wait already in progress.
- R4: Reads carry `cmd_op` = 0 and `cmd_addr` equal to the page index. They go to pages 0, 1, … NUM_PAGES-1 in order, then wrap to 0 for the next sweep.
- R5: A command holds `cmd_valid` and all its fields unchanged until `cmd_ready` is sampled high. After acceptance `cmd_valid` stays low until the decoder verdict (after a read) or the flash response (after a write-back).
- R6: After a good decode, the block issues `cmd_op` = 1 (in-place) with `cmd_dst` = the page index if the page's counter is below `reprog_limit`, and increments that counter. Otherwise it issues `cmd_op` = 2 (move) with `cmd_dst` = `free_addr` and clears the counter.
- R7: On `ecc_done` with `ecc_ok` low, no write-back is issued. `err_valid` pulses for one cycle with `err_addr` = the page index, the page's counter is left unchanged, and the next page's read follows.
- R8: `host_ready` is 0 from the cycle a write-back command is presented until the cycle after its response is accepted, and 1 again after that.
- R9: With `reprog_limit` = 0, every successful refresh is a move.
- R10: After reset is released, the first read raises `cmd_valid` on the edge that lies interval cycles after the first edge with reset low, using `pe_count` sampled at that first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pe_count | input | PE_W | Endured program/erase count of the block |
| reprog_limit | input | RPG_W | Maximum consecutive in-place reprograms per page |
| free_addr | input | ADDR_W | Spare physical page for a move |
| cmd_valid | output | 1 | Command request to the flash controller |
| cmd_ready | input | 1 | Controller accepts the command |
| cmd_op | output | 2 | 0 read, 1 in-place reprogram, 2 move |
| cmd_addr | output | ADDR_W | Page index being refreshed |
| cmd_dst | output | ADDR_W | Write-back destination |
| rsp_valid | input | 1 | Write-back completed |
| ecc_done | input | 1 | Decoder verdict available |
| ecc_ok | input | 1 | Decoder corrected the page |
| err_valid | output | 1 | One-cycle uncorrectable-page report |
| err_addr | output | ADDR_W | Index of the uncorrectable page |
| host_ready | output | 1 | Low while a write-back is in progress |

## Verification
The embedded properties check the command handshake on every cycle: fields stay stable while a command waits, nothing new is issued after an acceptance, the host is held off whenever a write-back command is shown, the error report is a single-cycle pulse, and addresses stay inside the page range. Only the directed scenarios can show the interval table selection and exact sweep spacing, that the wear count is sampled once per sweep, how the reprogram counters evolve across several sweeps into moves, that an uncorrectable page leaves its counter untouched, and the all-move behaviour at a zero limit.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_REPROG = 2'd1,
    OP_REMAP  = 2'd2
  } flash_op_e;

  typedef enum logic [2:0] {
    ST_START   = 3'd0,
    ST_WAIT    = 3'd1,
    ST_RD_REQ  = 3'd2,
    ST_ECC     = 3'd3,
    ST_WB_REQ  = 3'd4,
    ST_WB_WAIT = 3'd5,
    ST_NEXT    = 3'd6
  } sched_state_e;

endpackage

// File: rtl/refresh_interval_sel.sv
module refresh_interval_sel #(
  parameter int PE_W  = 16,
  parameter int TMR_W = 20,
  parameter int THR1  = 1000,
  parameter int THR2  = 3000,
  parameter int THR3  = 6000,
  parameter int INTV0 = 4096,
  parameter int INTV1 = 2048,
  parameter int INTV2 = 512,
  parameter int INTV3 = 128
) (
  input  logic [PE_W-1:0]  pe_count,
  output logic [TMR_W-1:0] interval
);
  localparam int NUM_THR = 3;
  localparam logic [PE_W-1:0]  THR_V  [NUM_THR] = '{PE_W'(THR1), PE_W'(THR2), PE_W'(THR3)};
  localparam logic [TMR_W-1:0] INTV_V [NUM_THR+1] =
    '{TMR_W'(INTV0), TMR_W'(INTV1), TMR_W'(INTV2), TMR_W'(INTV3)};

  logic [1:0] band;

  // Thresholds ascend, so the last one crossed names the wear band.
  always_comb begin
    band = 2'd0;
    for (int i = 0; i < NUM_THR; i++) begin
      if (pe_count >= THR_V[i]) band = 2'(i + 1);
    end
    interval = INTV_V[band];
  end

endmodule

// File: rtl/refresh_wear_ram.sv
module refresh_wear_ram #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int DW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  // Storage carries no reset so it maps to block RAM; a small flop
  // vector marks entries written since reset and masks stale content.
  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    mem_rd;
  logic [DEPTH-1:0] vld_q;
  logic             vld_rd;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_rd <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      vld_rd <= 1'b0;
    end else begin
      if (we) vld_q[waddr] <= 1'b1;
      vld_rd <= vld_q[raddr];
    end
  end

  assign rdata = vld_rd ? mem_rd : '0;

  // R6: counter writes stay inside the page range
  p_wr_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    we |-> (32'(waddr) < DEPTH));

endmodule

// File: rtl/refresh_sweep_timer.sv
module refresh_sweep_timer #(
  parameter int TMR_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             en,
  output logic             done
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (en && cnt_q > TMR_W'(1)) cnt_q <= cnt_q - TMR_W'(1);
  end

  // Expires on the cycle the count reaches one; a zero load acts as one.
  assign done = en && (cnt_q <= TMR_W'(1));

endmodule

// File: rtl/adaptive_refresh_sched.sv
module adaptive_refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int ADDR_W    = 12,
  parameter int PE_W      = 16,
  parameter int TMR_W     = 20,
  parameter int RPG_W     = 3,
  parameter int THR1      = 1000,
  parameter int THR2      = 3000,
  parameter int THR3      = 6000,
  parameter int INTV0     = 4096,
  parameter int INTV1     = 2048,
  parameter int INTV2     = 512,
  parameter int INTV3     = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PE_W-1:0]   pe_count,
  input  logic [RPG_W-1:0]  reprog_limit,
  input  logic [ADDR_W-1:0] free_addr,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [ADDR_W-1:0] cmd_dst,
  input  logic              rsp_valid,
  input  logic              ecc_done,
  input  logic              ecc_ok,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr,
  output logic              host_ready
);
  localparam int              PG_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam logic [PG_W-1:0] LAST_PG = PG_W'(NUM_PAGES - 1);

  sched_state_e      st_q, st_d;
  logic [PG_W-1:0]   page_q, page_d;
  logic              remap_q, remap_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  logic [TMR_W-1:0]  intv_sel;
  logic              tmr_done;
  logic [RPG_W-1:0]  wear_cnt;
  logic              wear_we;
  logic [RPG_W-1:0]  wear_wdata;

  logic              cmd_valid_q;
  flash_op_e         cmd_op_q;
  logic [ADDR_W-1:0] cmd_addr_q;
  logic              host_ready_q;
  logic              err_valid_q;
  logic [ADDR_W-1:0] err_addr_q;

  refresh_interval_sel #(
    .PE_W (PE_W),  .TMR_W(TMR_W),
    .THR1 (THR1),  .THR2 (THR2),  .THR3 (THR3),
    .INTV0(INTV0), .INTV1(INTV1), .INTV2(INTV2), .INTV3(INTV3)
  ) u_intv (
    .pe_count(pe_count),
    .interval(intv_sel)
  );

  refresh_sweep_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (st_q == ST_START),
    .load_val(intv_sel),
    .en      (st_q == ST_WAIT),
    .done    (tmr_done)
  );

  assign wear_we    = (st_q == ST_WB_REQ) && cmd_ready;
  assign wear_wdata = remap_q ? '0 : wear_cnt + RPG_W'(1);

  refresh_wear_ram #(.DEPTH(NUM_PAGES), .AW(PG_W), .DW(RPG_W)) u_wear (
    .clk  (clk),
    .rst  (rst),
    .we   (wear_we),
    .waddr(page_q),
    .wdata(wear_wdata),
    .raddr(page_q),
    .rdata(wear_cnt)
  );

  always_comb begin
    st_d    = st_q;
    page_d  = page_q;
    remap_d = remap_q;
    dst_d   = dst_q;
    unique case (st_q)
      ST_START:  st_d = ST_WAIT;
      ST_WAIT:   if (tmr_done) st_d = ST_RD_REQ;
      ST_RD_REQ: if (cmd_ready) st_d = ST_ECC;
      ST_ECC: begin
        if (ecc_done) begin
          if (ecc_ok) begin
            st_d    = ST_WB_REQ;
            remap_d = (wear_cnt >= reprog_limit);
            dst_d   = remap_d ? free_addr : ADDR_W'(page_q);
          end else begin
            st_d = ST_NEXT;
          end
        end
      end
      ST_WB_REQ:  if (cmd_ready) st_d = ST_WB_WAIT;
      ST_WB_WAIT: if (rsp_valid) st_d = ST_NEXT;
      ST_NEXT: begin
        if (page_q == LAST_PG) begin
          st_d   = ST_START;
          page_d = '0;
        end else begin
          st_d   = ST_RD_REQ;
          page_d = page_q + PG_W'(1);
        end
      end
      default: st_d = ST_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_START;
      page_q       <= '0;
      remap_q      <= 1'b0;
      dst_q        <= '0;
      cmd_valid_q  <= 1'b0;
      cmd_op_q     <= OP_READ;
      cmd_addr_q   <= '0;
      host_ready_q <= 1'b1;
      err_valid_q  <= 1'b0;
      err_addr_q   <= '0;
    end else begin
      st_q         <= st_d;
      page_q       <= page_d;
      remap_q      <= remap_d;
      dst_q        <= dst_d;
      cmd_valid_q  <= (st_d == ST_RD_REQ) || (st_d == ST_WB_REQ);
      cmd_op_q     <= (st_d == ST_WB_REQ) ? (remap_d ? OP_REMAP : OP_REPROG) : OP_READ;
      cmd_addr_q   <= ADDR_W'(page_d);
      host_ready_q <= !((st_d == ST_WB_REQ) || (st_d == ST_WB_WAIT));
      err_valid_q  <= (st_q == ST_ECC) && ecc_done && !ecc_ok;
      err_addr_q   <= ADDR_W'(page_q);
    end
  end

  assign cmd_valid  = cmd_valid_q;
  assign cmd_op     = cmd_op_q;
  assign cmd_addr   = cmd_addr_q;
  assign cmd_dst    = dst_q;
  assign host_ready = host_ready_q;
  assign err_valid  = err_valid_q;
  assign err_addr   = err_addr_q;

  // R5: a waiting command keeps every field
  p_cmd_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_dst)));

  // R5: one operation outstanding
  p_single_outstanding_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  // R8: host held off whenever a write-back is presented
  p_host_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_op != OP_READ)) |-> !host_ready);

  // R7: error report is a single-cycle pulse
  p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    err_valid |=> !err_valid);

  // R4: command addresses stay inside the swept range
  p_page_range_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (32'(cmd_addr) < NUM_PAGES));

endmodule

// File: tb/adaptive_refresh_sched_tb.sv
module adaptive_refresh_sched_tb_top;
  localparam int NP = 4;
  localparam int AW = 8;
  localparam int I0 = 40, I1 = 30, I2 = 20, I3 = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic [11:0]   pe_count;
  logic [2:0]    reprog_limit;
  logic [AW-1:0] free_addr;
  logic          cmd_valid, cmd_ready;
  logic [1:0]    cmd_op;
  logic [AW-1:0] cmd_addr, cmd_dst;
  logic          rsp_valid, ecc_done, ecc_ok;
  logic          err_valid;
  logic [AW-1:0] err_addr;
  logic          host_ready;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int last_rsp = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adaptive_refresh_sched #(
    .NUM_PAGES(NP), .ADDR_W(AW), .PE_W(12), .TMR_W(8), .RPG_W(3),
    .THR1(100), .THR2(200), .THR3(300),
    .INTV0(I0), .INTV1(I1), .INTV2(I2), .INTV3(I3)
  ) dut_i (
    .clk(clk), .rst(rst), .pe_count(pe_count), .reprog_limit(reprog_limit),
    .free_addr(free_addr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_dst(cmd_dst),
    .rsp_valid(rsp_valid), .ecc_done(ecc_done), .ecc_ok(ecc_ok),
    .err_valid(err_valid), .err_addr(err_addr), .host_ready(host_ready)
  );

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Wait for the next read and compare the spacing since the last response.
  task automatic expect_gap(input string req, input int exp);
    while (!cmd_valid) @(negedge clk);
    chk_eq(req, "sweep spacing", cyc - last_rsp, exp);
  endtask

  // Act as flash controller and decoder for one page.
  task automatic serve_page(input int p, input bit ok, input int exp_op, input int exp_dst,
                            input int rdy_dly, input int ecc_dly, input string req);
    free_addr = AW'(8'h80 + p);
    while (!cmd_valid) @(negedge clk);
    chk_eq("R4", "read op", cmd_op, 0);
    chk_eq("R4", "read page", cmd_addr, p);
    for (int i = 0; i < rdy_dly; i++) begin
      @(negedge clk);
      chk_eq("R5", "valid held", cmd_valid, 1);
      chk_eq("R5", "addr held", cmd_addr, p);
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    chk_eq("R5", "idle after read accept", cmd_valid, 0);
    for (int i = 0; i < ecc_dly; i++) begin
      @(negedge clk);
      chk_eq("R5", "idle while decode pending", cmd_valid, 0);
    end
    ecc_done = 1'b1;
    ecc_ok   = ok;
    @(negedge clk);
    ecc_done = 1'b0;
    ecc_ok   = 1'b0;
    if (!ok) begin
      chk_eq("R7", "error pulse", err_valid, 1);
      chk_eq("R7", "error page", err_addr, p);
      chk_eq("R7", "no write-back", cmd_valid, 0);
      @(negedge clk);
      chk_eq("R7", "pulse one cycle", err_valid, 0);
      chk_eq("R7", "next is a read", cmd_op, 0);
      return;
    end
    chk_eq(req, "write-back valid", cmd_valid, 1);
    chk_eq(req, "write-back op", cmd_op, exp_op);
    chk_eq(req, "write-back dst", cmd_dst, exp_dst);
    chk_eq("R8", "host held at issue", host_ready, 0);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    chk_eq("R8", "host held awaiting response", host_ready, 0);
    chk_eq("R5", "idle awaiting response", cmd_valid, 0);
    rsp_valid = 1'b1;
    last_rsp  = cyc;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk_eq("R8", "host released", host_ready, 1);
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    chk_eq("R1", "cmd_valid in reset", cmd_valid, 0);
    chk_eq("R1", "err_valid in reset", err_valid, 0);
    chk_eq("R1", "host_ready in reset", host_ready, 1);
    rst = 1'b0;
    last_rsp = cyc;
    @(negedge clk);
    chk_eq("R1", "idle after release", cmd_valid, 0);
  endtask

  // R10 and R6: first sweep, counters from zero, all in place
  task automatic t_first_sweep;
    expect_gap("R10", I0 + 1);
    pe_count = 12'd150;
    for (int p = 0; p < NP; p++) serve_page(p, 1'b1, 1, p, 0, 0, "R6");
  endtask

  // R2 and R3: band one chosen, later change ignored
  task automatic t_sample_once;
    repeat (3) @(negedge clk);
    pe_count = 12'd350;
    expect_gap("R2 R3", I1 + 3);
    for (int p = 0; p < NP; p++) serve_page(p, 1'b1, 1, p, 0, 0, "R4");
  endtask

  // R6 limit reached -> moves; R7 uncorrectable page 2
  task automatic t_limit_and_error;
    expect_gap("R2", I3 + 3);
    pe_count = 12'd250;
    serve_page(0, 1'b1, 2, 8'h80, 0, 0, "R6");
    serve_page(1, 1'b1, 2, 8'h81, 0, 0, "R6");
    serve_page(2, 1'b0, 0, 0,     0, 0, "R7");
    serve_page(3, 1'b1, 2, 8'h83, 0, 0, "R6");
  endtask

  // R5 stalls; R7 counter of page 2 kept so it moves now
  task automatic t_stall_and_kept_count;
    expect_gap("R2", I2 + 3);
    serve_page(0, 1'b1, 1, 0,     3, 4, "R6");
    serve_page(1, 1'b1, 1, 1,     0, 0, "R6");
    serve_page(2, 1'b1, 2, 8'h82, 0, 0, "R7");
    serve_page(3, 1'b1, 1, 3,     2, 0, "R6");
    reprog_limit = 3'd0;
  endtask

  // R9: zero limit forces moves everywhere
  task automatic t_zero_limit;
    expect_gap("R2", I2 + 3);
    for (int p = 0; p < NP; p++) serve_page(p, 1'b1, 2, 8'h80 + p, 0, 0, "R9");
  endtask

  initial begin
    rst          = 1'b1;
    pe_count     = 12'd0;
    reprog_limit = 3'd2;
    free_addr    = '0;
    cmd_ready    = 1'b0;
    rsp_valid    = 1'b0;
    ecc_done     = 1'b0;
    ecc_ok       = 1'b0;
    t_reset();
    t_first_sweep();
    t_sample_once();
    t_limit_and_error();
    t_stall_and_kept_count();
    t_zero_limit();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule